// File: doc/BRIEF.md
# Dual-View Stack and Packed-Integer Register File

This block holds eight 80-bit physical entries that two kinds of instruction share. Floating-point instructions name an entry by its distance from a 3-bit top-of-stack pointer, so ST(i) lands on physical entry (TOS + i) mod 8. Packed-integer SIMD instructions name eight 64-bit registers that sit permanently in the low 64 bits of physical entries 0 to 7, whatever the pointer holds. A SIMD write fills the upper 16 bits of its entry with ones in the same cycle.

Every SIMD access, read or write, passes through a gate driven by three control flags: an emulation flag, a task-switched flag and a monitor flag. The emulation flag turns the access into an invalid-opcode fault. The task-switched flag alone turns it into a device-not-available fault. With both clear, the access executes. A blocked access changes nothing and raises a one-cycle fault strobe that carries a 1-bit code. Floating-point accesses and pointer updates do not pass through the gate.

Top module: `simd_fp_regfile`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, every entry reads zero, the pointer is 0, both read outputs are zero, and fault_o and fault_code_o are 0.
- R2: A floating-point read or write of stack index i reaches physical entry (TOS + i) mod 8, using the pointer value current in the request cycle.
- R3: SIMD register n always reaches bits 63:0 of physical entry n, whatever the pointer holds, and a SIMD read returns those 64 bits.
- R4: An executed SIMD write stores its data in bits 63:0 and 16'hFFFF in bits 79:64 of the entry.
- R5: fsw_o carries the pointer in bits 13:11, and all of its other bits are 0.
- R6: A pointer load sets TOS to tos_ld_val_i and takes priority over push and pop. Push alone decrements TOS mod 8 and pop alone increments it mod 8. Push and pop together leave TOS unchanged. The new value shows on the cycle after the request.
- R7: A SIMD request with cr_em_i=1 does not execute and gives fault_o=1 with fault_code_o=0 (invalid opcode) on the next cycle, whatever cr_ts_i holds.
- R8: A SIMD request with cr_em_i=0 and cr_ts_i=1 does not execute and gives fault_o=1 with fault_code_o=1 (device not available) on the next cycle.
- R9: A SIMD request with cr_em_i=0 and cr_ts_i=0 executes and raises no fault, whatever cr_mp_i holds.
- R10: A blocked SIMD access changes no entry and leaves simd_rd_data_o unchanged. fault_o is high only on the cycle after a blocked request, and fault_code_o is 0 whenever fault_o is 0.
- R11: Read data shows on the cycle after the request and holds until the next read on that port. A read of an entry that is written in the same cycle returns the old contents.
- R12: When an executed SIMD write and a floating-point write hit the same physical entry in the same cycle, the SIMD write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cr_em_i | input | 1 | Emulation control flag |
| cr_mp_i | input | 1 | Monitor control flag (no effect on the outcome) |
| cr_ts_i | input | 1 | Task-switched control flag |
| tos_ld_en_i | input | 1 | Load the pointer from tos_ld_val_i |
| tos_ld_val_i | input | 3 | Pointer load value |
| tos_push_i | input | 1 | Decrement the pointer |
| tos_pop_i | input | 1 | Increment the pointer |
| fp_wr_en_i | input | 1 | Floating-point write request |
| fp_wr_idx_i | input | 3 | Stack index of the write |
| fp_wr_data_i | input | 80 | Floating-point write data |
| fp_rd_en_i | input | 1 | Floating-point read request |
| fp_rd_idx_i | input | 3 | Stack index of the read |
| fp_rd_data_o | output | 80 | Floating-point read data |
| simd_wr_en_i | input | 1 | SIMD write request |
| simd_wr_idx_i | input | 3 | SIMD register written |
| simd_wr_data_i | input | 64 | SIMD write data |
| simd_rd_en_i | input | 1 | SIMD read request |
| simd_rd_idx_i | input | 3 | SIMD register read |
| simd_rd_data_o | output | 64 | SIMD read data |
| fsw_o | output | 16 | Status word carrying the pointer |
| fault_o | output | 1 | One-cycle fault strobe |
| fault_code_o | output | 1 | 0 invalid opcode, 1 device not available |

## Verification
The gating assertions assume the control flags seen with a request are the ones that decide it. They look one cycle back at the flags and enables together, so a flag that changes between a request and its strobe does not affect them. The pointer assertion assumes that when no load is made, push and pop arriving together cancel. The stimulus changes flags and enables only at falling edges, holds every flag steady for the whole request cycle, and mixes flag settings, pointer moves and same-entry collisions. Random runs set the fault flags rarely, so most SIMD traffic executes.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned N_ENT  = 8;
  localparam int unsigned ENT_W  = 80;
  localparam int unsigned SIMD_W = 64;
  localparam int unsigned IDX_W  = $clog2(N_ENT);
  localparam int unsigned FSW_W  = 16;
  localparam int unsigned TOS_LSB = 11;

  typedef enum logic {
    FLT_UD = 1'b0,
    FLT_NM = 1'b1
  } fault_code_e;
endpackage

// File: rtl/rf_gate.sv
module rf_gate
  import rf_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        em_i,
  input  logic        ts_i,
  input  logic        simd_wr_i,
  input  logic        simd_rd_i,
  output logic        simd_wr_go_o,
  output logic        simd_rd_go_o,
  output logic        fault_o,
  output fault_code_e fault_code_o
);
  logic        req, blocked;
  fault_code_e code_d;

  assign req     = simd_wr_i | simd_rd_i;
  assign blocked = req & (em_i | ts_i);
  // emulation flag outranks task-switched
  assign code_d  = em_i ? FLT_UD : FLT_NM;

  assign simd_wr_go_o = simd_wr_i & ~blocked;
  assign simd_rd_go_o = simd_rd_i & ~blocked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_o      <= 1'b0;
      fault_code_o <= FLT_UD;
    end else begin
      fault_o      <= blocked;
      fault_code_o <= blocked ? code_d : FLT_UD;
    end
  end
endmodule

// File: rtl/rf_tos.sv
module rf_tos
  import rf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_en_i,
  input  logic [IDX_W-1:0] ld_val_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [IDX_W-1:0] fp_wr_rel_i,
  input  logic [IDX_W-1:0] fp_rd_rel_i,
  output logic [IDX_W-1:0] fp_wr_phys_o,
  output logic [IDX_W-1:0] fp_rd_phys_o,
  output logic [IDX_W-1:0] tos_o
);
  logic [IDX_W-1:0] tos_q, tos_d;

  always_comb begin
    tos_d = tos_q;
    if (ld_en_i)              tos_d = ld_val_i;
    else if (push_i && !pop_i) tos_d = tos_q - IDX_W'(1);
    else if (pop_i && !push_i) tos_d = tos_q + IDX_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tos_q <= '0;
    else         tos_q <= tos_d;
  end

  // width-limited add gives mod N_ENT wrap
  assign fp_wr_phys_o = tos_q + fp_wr_rel_i;
  assign fp_rd_phys_o = tos_q + fp_rd_rel_i;
  assign tos_o        = tos_q;
endmodule

// File: rtl/rf_array.sv
module rf_array
  import rf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fp_we_i,
  input  logic [IDX_W-1:0]  fp_widx_i,
  input  logic [ENT_W-1:0]  fp_wdata_i,
  input  logic              fp_re_i,
  input  logic [IDX_W-1:0]  fp_ridx_i,
  output logic [ENT_W-1:0]  fp_rdata_o,
  input  logic              simd_we_i,
  input  logic [IDX_W-1:0]  simd_widx_i,
  input  logic [SIMD_W-1:0] simd_wdata_i,
  input  logic              simd_re_i,
  input  logic [IDX_W-1:0]  simd_ridx_i,
  output logic [SIMD_W-1:0] simd_rdata_o
);
  localparam int unsigned HI_W = ENT_W - SIMD_W;

  logic [ENT_W-1:0] ent_q [N_ENT];

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic hit_simd, hit_fp;
    assign hit_simd = simd_we_i && (simd_widx_i == IDX_W'(e));
    assign hit_fp   = fp_we_i   && (fp_widx_i   == IDX_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       ent_q[e] <= '0;
      else if (hit_simd) ent_q[e] <= {{HI_W{1'b1}}, simd_wdata_i};
      else if (hit_fp)   ent_q[e] <= fp_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fp_rdata_o   <= '0;
      simd_rdata_o <= '0;
    end else begin
      if (fp_re_i)   fp_rdata_o   <= ent_q[fp_ridx_i];
      if (simd_re_i) simd_rdata_o <= ent_q[simd_ridx_i][SIMD_W-1:0];
    end
  end
endmodule

// File: rtl/simd_fp_regfile.sv
module simd_fp_regfile
  import rf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cr_em_i,
  input  logic              cr_mp_i,
  input  logic              cr_ts_i,
  input  logic              tos_ld_en_i,
  input  logic [IDX_W-1:0]  tos_ld_val_i,
  input  logic              tos_push_i,
  input  logic              tos_pop_i,
  input  logic              fp_wr_en_i,
  input  logic [IDX_W-1:0]  fp_wr_idx_i,
  input  logic [ENT_W-1:0]  fp_wr_data_i,
  input  logic              fp_rd_en_i,
  input  logic [IDX_W-1:0]  fp_rd_idx_i,
  output logic [ENT_W-1:0]  fp_rd_data_o,
  input  logic              simd_wr_en_i,
  input  logic [IDX_W-1:0]  simd_wr_idx_i,
  input  logic [SIMD_W-1:0] simd_wr_data_i,
  input  logic              simd_rd_en_i,
  input  logic [IDX_W-1:0]  simd_rd_idx_i,
  output logic [SIMD_W-1:0] simd_rd_data_o,
  output logic [FSW_W-1:0]  fsw_o,
  output logic              fault_o,
  output logic              fault_code_o
);
  logic             simd_wr_go, simd_rd_go;
  logic [IDX_W-1:0] fp_wr_phys, fp_rd_phys, tos;
  fault_code_e      code;
  logic             unused_mp;

  // monitor flag does not alter the gate outcome
  assign unused_mp = cr_mp_i;

  rf_gate u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .em_i         (cr_em_i),
    .ts_i         (cr_ts_i),
    .simd_wr_i    (simd_wr_en_i),
    .simd_rd_i    (simd_rd_en_i),
    .simd_wr_go_o (simd_wr_go),
    .simd_rd_go_o (simd_rd_go),
    .fault_o      (fault_o),
    .fault_code_o (code)
  );

  rf_tos u_tos (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ld_en_i      (tos_ld_en_i),
    .ld_val_i     (tos_ld_val_i),
    .push_i       (tos_push_i),
    .pop_i        (tos_pop_i),
    .fp_wr_rel_i  (fp_wr_idx_i),
    .fp_rd_rel_i  (fp_rd_idx_i),
    .fp_wr_phys_o (fp_wr_phys),
    .fp_rd_phys_o (fp_rd_phys),
    .tos_o        (tos)
  );

  rf_array u_array (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fp_we_i      (fp_wr_en_i),
    .fp_widx_i    (fp_wr_phys),
    .fp_wdata_i   (fp_wr_data_i),
    .fp_re_i      (fp_rd_en_i),
    .fp_ridx_i    (fp_rd_phys),
    .fp_rdata_o   (fp_rd_data_o),
    .simd_we_i    (simd_wr_go),
    .simd_widx_i  (simd_wr_idx_i),
    .simd_wdata_i (simd_wr_data_i),
    .simd_re_i    (simd_rd_go),
    .simd_ridx_i  (simd_rd_idx_i),
    .simd_rdata_o (simd_rd_data_o)
  );

  always_comb begin
    fsw_o = '0;
    fsw_o[TOS_LSB +: IDX_W] = tos;
  end

  assign fault_code_o = code;
endmodule

// File: rtl/rf_checker.sv
module rf_checker
  import rf_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cr_em_i,
  input logic              cr_ts_i,
  input logic              tos_ld_en_i,
  input logic              tos_push_i,
  input logic              tos_pop_i,
  input logic              fp_rd_en_i,
  input logic              simd_wr_en_i,
  input logic              simd_rd_en_i,
  input logic [ENT_W-1:0]  fp_rd_data_o,
  input logic [SIMD_W-1:0] simd_rd_data_o,
  input logic [FSW_W-1:0]  fsw_o,
  input logic              fault_o,
  input logic              fault_code_o
);
  logic armed_q, req;
  assign req = simd_wr_en_i | simd_rd_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  AST_UD_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(req && cr_em_i) |-> fault_o && !fault_code_o); // R7

  AST_NM_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(req && !cr_em_i && cr_ts_i) |-> fault_o && fault_code_o); // R8

  AST_NO_SPURIOUS_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && !$past(req && (cr_em_i || cr_ts_i)) |-> !fault_o && !fault_code_o); // R9

  AST_FSW_LAYOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsw_o[15:14] == 2'b00 && fsw_o[10:0] == '0); // R5

  AST_TOS_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(!tos_ld_en_i && (tos_push_i == tos_pop_i)) |-> $stable(fsw_o)); // R6

  AST_BLOCKED_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(!(simd_rd_en_i && !cr_em_i && !cr_ts_i)) |-> $stable(simd_rd_data_o)); // R10

  AST_FP_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && !$past(fp_rd_en_i) |-> $stable(fp_rd_data_o)); // R11
endmodule

bind simd_fp_regfile rf_checker u_rf_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cr_em_i        (cr_em_i),
  .cr_ts_i        (cr_ts_i),
  .tos_ld_en_i    (tos_ld_en_i),
  .tos_push_i     (tos_push_i),
  .tos_pop_i      (tos_pop_i),
  .fp_rd_en_i     (fp_rd_en_i),
  .simd_wr_en_i   (simd_wr_en_i),
  .simd_rd_en_i   (simd_rd_en_i),
  .fp_rd_data_o   (fp_rd_data_o),
  .simd_rd_data_o (simd_rd_data_o),
  .fsw_o          (fsw_o),
  .fault_o        (fault_o),
  .fault_code_o   (fault_code_o)
);

// File: tb/simd_fp_regfile_test.sv
`timescale 1ns/1ps
module simd_fp_regfile_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cr_em_i = 0, cr_mp_i = 1, cr_ts_i = 0;
  logic        tos_ld_en_i = 0, tos_push_i = 0, tos_pop_i = 0;
  logic [2:0]  tos_ld_val_i = 0;
  logic        fp_wr_en_i = 0, fp_rd_en_i = 0;
  logic [2:0]  fp_wr_idx_i = 0, fp_rd_idx_i = 0;
  logic [79:0] fp_wr_data_i = 0;
  logic        simd_wr_en_i = 0, simd_rd_en_i = 0;
  logic [2:0]  simd_wr_idx_i = 0, simd_rd_idx_i = 0;
  logic [63:0] simd_wr_data_i = 0;
  logic [79:0] fp_rd_data_o;
  logic [63:0] simd_rd_data_o;
  logic [15:0] fsw_o;
  logic        fault_o, fault_code_o;

  int total = 0, bad = 0;
  logic [79:0] m_ent [8];
  int          m_tos = 0;
  logic [79:0] e_fp = '0;
  logic [63:0] e_simd = '0;
  logic        e_flt = 0, e_code = 0;
  string       ftag = "R1";

  always #10 clk_i = ~clk_i;

  simd_fp_regfile uut (.*);

  task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    chk({tag, " fp_rd"}, fp_rd_data_o, e_fp);
    chk({tag, " simd_rd"}, {16'h0, simd_rd_data_o}, {16'h0, e_simd});
    chk("R5 fsw", {64'h0, fsw_o}, {64'h0, 2'b00, 3'(m_tos), 11'h0});
    chk({ftag, " fault"}, {78'h0, fault_o, fault_code_o}, {78'h0, e_flt, e_code});
  endtask

  // apply current inputs for one cycle, advance model, compare at next falling edge
  task automatic step(input string tag);
    logic req, blk;
    req = simd_wr_en_i | simd_rd_en_i;
    blk = req & (cr_em_i | cr_ts_i);
    ftag = !req ? "R10" : cr_em_i ? "R7" : cr_ts_i ? "R8" : "R9";
    e_flt  = blk;
    e_code = blk & ~cr_em_i;
    if (fp_rd_en_i) e_fp = m_ent[(m_tos + int'(fp_rd_idx_i)) & 7];
    if (simd_rd_en_i && !blk) e_simd = m_ent[simd_rd_idx_i][63:0];
    if (fp_wr_en_i) m_ent[(m_tos + int'(fp_wr_idx_i)) & 7] = fp_wr_data_i;
    if (simd_wr_en_i && !blk) m_ent[simd_wr_idx_i] = {16'hFFFF, simd_wr_data_i};
    if (tos_ld_en_i) m_tos = int'(tos_ld_val_i);
    else if (tos_push_i && !tos_pop_i) m_tos = (m_tos + 7) & 7;
    else if (tos_pop_i && !tos_push_i) m_tos = (m_tos + 1) & 7;
    @(negedge clk_i);
    compare(tag);
  endtask

  task automatic idle();
    tos_ld_en_i = 0; tos_push_i = 0; tos_pop_i = 0;
    fp_wr_en_i = 0; fp_rd_en_i = 0; simd_wr_en_i = 0; simd_rd_en_i = 0;
  endtask

  task automatic fp_wr(input logic [2:0] i, input logic [79:0] d, input string tag);
    idle(); fp_wr_en_i = 1; fp_wr_idx_i = i; fp_wr_data_i = d; step(tag);
  endtask
  task automatic fp_rd(input logic [2:0] i, input string tag);
    idle(); fp_rd_en_i = 1; fp_rd_idx_i = i; step(tag);
  endtask
  task automatic mm_wr(input logic [2:0] i, input logic [63:0] d, input string tag);
    idle(); simd_wr_en_i = 1; simd_wr_idx_i = i; simd_wr_data_i = d; step(tag);
  endtask
  task automatic mm_rd(input logic [2:0] i, input string tag);
    idle(); simd_rd_en_i = 1; simd_rd_idx_i = i; step(tag);
  endtask
  task automatic tos_ld(input logic [2:0] v);
    idle(); tos_ld_en_i = 1; tos_ld_val_i = v; step("R6 load");
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) m_ent[k] = '0;
    repeat (3) @(negedge clk_i);
    compare("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R1 after reset");
    for (int k = 0; k < 8; k++) fp_rd(3'(k), "R1 cleared");

    // R2: stack-relative with TOS=0, then moved
    for (int k = 0; k < 8; k++) fp_wr(3'(k), {16'h1000 + 16'(k), 64'hA5A5_0000_0000_0000 + 64'(k)}, "R2 write");
    tos_ld(3'd5);
    for (int k = 0; k < 8; k++) fp_rd(3'(k), "R2 rel read tos5");
    fp_wr(3'd1, 80'h7777_1122_3344_5566_7788, "R2 wr ST1");
    // R3: physical mapping ignores TOS
    for (int k = 0; k < 8; k++) mm_rd(3'(k), "R3 fixed map");
    // R4: upper bits become ones
    mm_wr(3'd2, 64'hDEAD_BEEF_0123_4567, "R4 simd wr");
    fp_rd(3'd5, "R4 top ones");
    tos_ld(3'd0);
    fp_rd(3'd2, "R4 top ones tos0");

    // R6: push/pop with wrap
    idle(); tos_push_i = 1; step("R6 push wrap");
    idle(); tos_pop_i = 1; step("R6 pop wrap");
    idle(); tos_push_i = 1; tos_pop_i = 1; step("R6 both");
    idle(); tos_ld_en_i = 1; tos_ld_val_i = 3'd3; tos_push_i = 1; step("R6 load priority");
    idle(); tos_ld_en_i = 1; tos_ld_val_i = 3'd7; tos_pop_i = 1; step("R6 load priority pop");
    idle(); tos_pop_i = 1; step("R6 pop 7to0");
    mm_rd(3'd6, "R3 tos0");

    // R7/R8/R9/R10 gating
    cr_em_i = 1; cr_ts_i = 0;
    mm_wr(3'd4, 64'h1111_2222_3333_4444, "R10 blocked wr");
    mm_rd(3'd4, "R10 blocked rd");
    cr_ts_i = 1;
    mm_wr(3'd4, 64'h5555_6666_7777_8888, "R7 priority");
    cr_em_i = 0;
    mm_rd(3'd2, "R8 nm rd");
    mm_wr(3'd4, 64'h9999_AAAA_BBBB_CCCC, "R8 nm wr");
    idle(); step("R10 strobe drop");
    cr_ts_i = 0;
    fp_rd(3'd4, "R10 entry unchanged");
    cr_mp_i = 0;
    mm_wr(3'd4, 64'h0F0F_0F0F_F0F0_F0F0, "R9 mp0 exec");
    mm_rd(3'd4, "R9 mp0 rd");
    cr_mp_i = 1;
    // blocked FP-side traffic still executes
    cr_em_i = 1;
    idle(); fp_wr_en_i = 1; fp_wr_idx_i = 3'd0; fp_wr_data_i = 80'h1234_5678_9ABC_DEF0_1357;
    simd_rd_en_i = 1; simd_rd_idx_i = 3'd0; step("R10 fp during fault");
    cr_em_i = 0;

    // R11: read during write returns old
    idle(); fp_wr_en_i = 1; fp_wr_idx_i = 3'd3; fp_wr_data_i = 80'hCAFE_0000_1111_2222_3333;
    fp_rd_en_i = 1; fp_rd_idx_i = 3'd3; simd_rd_en_i = 1; simd_rd_idx_i = 3'd3; step("R11 rdw old");
    fp_rd(3'd3, "R11 new");
    // R12: collision, SIMD wins
    idle(); fp_wr_en_i = 1; fp_wr_idx_i = 3'd6; fp_wr_data_i = 80'hBAD0_BAD0_BAD0_BAD0_BAD0;
    simd_wr_en_i = 1; simd_wr_idx_i = 3'd6; simd_wr_data_i = 64'h6666_0000_6666_0000; step("R12 collide");
    fp_rd(3'd6, "R12 simd wins");

    // mixed random traffic
    for (int n = 0; n < 600; n++) begin
      cr_em_i = ($urandom % 10) == 0;
      cr_ts_i = ($urandom % 8) == 0;
      cr_mp_i = 1'($urandom);
      tos_ld_en_i = ($urandom % 9) == 0; tos_ld_val_i = 3'($urandom);
      tos_push_i = 1'($urandom); tos_pop_i = 1'($urandom);
      fp_wr_en_i = 1'($urandom); fp_wr_idx_i = 3'($urandom);
      fp_wr_data_i = {16'($urandom), 32'($urandom), 32'($urandom)};
      fp_rd_en_i = 1'($urandom); fp_rd_idx_i = 3'($urandom);
      simd_wr_en_i = 1'($urandom); simd_wr_idx_i = 3'($urandom);
      simd_wr_data_i = {32'($urandom), 32'($urandom)};
      simd_rd_en_i = 1'($urandom); simd_rd_idx_i = 3'($urandom);
      step("R2 R3 R12 random");
    end
    idle(); cr_em_i = 0; cr_ts_i = 0;
    step("R11 final");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule